// File: doc/BRIEF.md
# Fragment Quad Chunk Packer

The packer sits between a rasterizer and a fragment shading stage. The rasterizer hands it one screen tile per transfer. A tile is a 2x2 arrangement of quads, and each quad holds four fragments. Every fragment carries a coverage bit and a block of interpolated attributes. The packer keeps only the quads that have at least one covered fragment. It lays those quads into fixed-size chunks of four quad slots, which is sixteen fragments. Each chunk gets a liveness bit per fragment, a screen position per quad and one copy of the triangle's uniform data.

A chunk is handed downstream as soon as its last quad slot is filled, even in the middle of a tile or a triangle. When the rasterizer marks the last tile of a triangle, a partly filled chunk is closed with its unused slots marked dead, so that no chunk ever mixes two triangles. Both sides use valid/ready handshakes. A stalled consumer pushes back onto the tile input, and no quad is lost.

Top module: `fqp_chunk_packer`

## Requirements
- R1: Reset is synchronous and active low. After reset `out_valid` is 0 and `in_ready` is 1, and any partly filled chunk is discarded, so the first quad after reset goes into quad slot 0.
- R2: A chunk is emitted once all four of its quad slots are filled. Quad slot s occupies fragment positions 4s to 4s+3 of `out_live` and `out_attr`, with ATTR_W attribute bits per fragment.
- R3: A quad whose four coverage bits are all zero is skipped. The remaining quads of a tile are taken in ascending quad index and fill consecutive slots, so the used slots of a chunk always start at slot 0 with no gap.
- R4: Within a tile, quad index q is 0 for top-left, 1 for top-right, 2 for bottom-left and 3 for bottom-right, and input fragment f of quad q is bit 4q+f of `in_cov`. A packed quad's position is x = {tile_x, q[0]} and y = {tile_y, q[1]}.
- R5: Each liveness bit equals the input coverage bit of that fragment. A partly covered quad is kept whole, and the attributes of all four of its fragments are copied unchanged.
- R6: `out_uniform` carries the triangle's uniform value once per chunk.
- R7: If a chunk fills before a tile is finished, it is emitted and the tile's remaining non-empty quads continue from slot 0 of a new chunk.
- R8: When the tile marked as the last of its triangle has been packed and the chunk is partly filled, the chunk is emitted with every liveness bit of its unused slots at 0, and the next triangle begins at slot 0 of a new chunk.
- R9: No chunk without a live fragment is ever emitted. In particular, a triangle end that finds the chunk empty produces no output.
- R10: While `out_valid` is 1 and `out_ready` is 0, every output stays unchanged. Every packed quad is eventually delivered exactly once.
- R11: One tile is held at a time. `in_ready` is 0 from the cycle after a tile is accepted until all of that tile's quads have been packed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Tile offered |
| in_ready | output | 1 | Tile accepted when high together with in_valid |
| in_cov | input | 16 | Coverage bit per fragment, bit 4q+f |
| in_attr | input | 16*ATTR_W | Interpolated attributes per fragment, same order as in_cov |
| in_tile_x | input | COORD_W | Tile column in units of two quads |
| in_tile_y | input | COORD_W | Tile row in units of two quads |
| in_uniform | input | UNI_W | Uniform data of the tile's triangle |
| in_tri_end | input | 1 | Tile is the last one of its triangle |
| out_valid | output | 1 | Chunk offered |
| out_ready | input | 1 | Consumer takes the chunk when high together with out_valid |
| out_live | output | 4*CHUNK_QUADS | Liveness bit per fragment slot |
| out_attr | output | 4*CHUNK_QUADS*ATTR_W | Attributes per fragment slot |
| out_quad_x | output | CHUNK_QUADS*(COORD_W+1) | Quad x position per quad slot |
| out_quad_y | output | CHUNK_QUADS*(COORD_W+1) | Quad y position per quad slot |
| out_uniform | output | UNI_W | Triangle uniform data, one copy per chunk |

## Verification
The assertions assume that the rasterizer keeps every tile field steady while `in_valid` is high and unaccepted, and that tiles of one triangle carry the same uniform value. They make no assumption about `out_ready`, which may drop in any cycle. The stimulus changes tile inputs only in the cycle after a handshake. It assigns one uniform value to each triangle, and it exercises the output side both with `out_ready` held high and with a repeating two-cycle stall pattern. It also covers empty tiles, tiles whose quads straddle a chunk boundary, triangle ends that find the chunk full or empty, and a reset that arrives while a chunk is partly filled.

// File: rtl/fqp_pkg.sv
// Shared constants and types for the fragment quad chunk packer.
// Assumes the fixed tile shape of 2x2 quads with four fragments per quad.
package fqp_pkg;
    localparam int QUAD_FRAGS = 4;
    localparam int TILE_QUADS = 4;
    localparam int TILE_FRAGS = TILE_QUADS * QUAD_FRAGS;
    localparam int QIDX_W     = $clog2(TILE_QUADS);

    typedef logic [QIDX_W-1:0] quad_idx_t;
endpackage

// File: rtl/fqp_tile_hold.sv
// Holds one accepted tile and tracks which of its non-empty quads are still
// waiting to be packed. Assumes the packer takes at most one quad per cycle
// and raises release_tile only once no quad remains.
module fqp_tile_hold
    import fqp_pkg::*;
#(
    parameter int ATTR_W  = 8,
    parameter int COORD_W = 8,
    parameter int UNI_W   = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_valid,
    output logic                         in_ready,
    input  logic [TILE_FRAGS-1:0]        in_cov,
    input  logic [TILE_FRAGS*ATTR_W-1:0] in_attr,
    input  logic [COORD_W-1:0]           in_tile_x,
    input  logic [COORD_W-1:0]           in_tile_y,
    input  logic [UNI_W-1:0]             in_uniform,
    input  logic                         in_tri_end,
    input  logic                         take,
    input  quad_idx_t                    take_idx,
    input  logic                         release_tile,
    output logic                         hold_valid,
    output logic [TILE_QUADS-1:0]        hold_rem,
    output logic [TILE_FRAGS-1:0]        hold_cov,
    output logic [TILE_FRAGS*ATTR_W-1:0] hold_attr,
    output logic [COORD_W-1:0]           hold_x,
    output logic [COORD_W-1:0]           hold_y,
    output logic [UNI_W-1:0]             hold_uni,
    output logic                         hold_end
);

    logic [TILE_QUADS-1:0] quad_nonempty;
    logic                  accept;

    // a quad counts as present when any of its fragments is covered
    for (genvar q = 0; q < TILE_QUADS; q++) begin : gen_ne
        assign quad_nonempty[q] = |in_cov[q*QUAD_FRAGS +: QUAD_FRAGS];
    end

    assign in_ready = !hold_valid;
    assign accept   = in_valid && in_ready;

    // occupancy flag and pending-quad mask of the held tile
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_valid <= 1'b0;
            hold_rem   <= '0;
        end else if (accept) begin
            hold_valid <= 1'b1;
            hold_rem   <= quad_nonempty;
        end else begin
            if (take) begin
                hold_rem[take_idx] <= 1'b0;
            end
            if (release_tile) begin
                hold_valid <= 1'b0;
            end
        end
    end

    // tile payload captured on acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_cov  <= '0;
            hold_attr <= '0;
            hold_x    <= '0;
            hold_y    <= '0;
            hold_uni  <= '0;
            hold_end  <= 1'b0;
        end else if (accept) begin
            hold_cov  <= in_cov;
            hold_attr <= in_attr;
            hold_x    <= in_tile_x;
            hold_y    <= in_tile_y;
            hold_uni  <= in_uniform;
            hold_end  <= in_tri_end;
        end
    end

endmodule

// File: rtl/fqp_quad_pick.sv
// Chooses the lowest-indexed quad still pending in the held tile.
// Purely combinational; idx is zero when nothing is pending.
module fqp_quad_pick
    import fqp_pkg::*;
(
    input  logic [TILE_QUADS-1:0] rem,
    output logic                  any,
    output quad_idx_t             idx
);

    // find-first from the low end, scanned downward so the lowest set bit wins
    always_comb begin
        any = |rem;
        idx = '0;
        for (int q = TILE_QUADS - 1; q >= 0; q--) begin
            if (rem[q]) begin
                idx = quad_idx_t'(q);
            end
        end
    end

endmodule

// File: rtl/fqp_chunk_build.sv
// Accumulates packed quads into the open chunk and decides when to take a
// quad, close the chunk, and release the held tile. The merged view (m_*)
// is the chunk as it looks with this cycle's quad included, so a full
// chunk leaves in the same cycle its last slot is written. Assumes out_free
// means the output register can load in this cycle.
module fqp_chunk_build
    import fqp_pkg::*;
#(
    parameter int ATTR_W      = 8,
    parameter int COORD_W     = 8,
    parameter int UNI_W       = 16,
    parameter int CHUNK_QUADS = 4
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  hold_valid,
    input  logic                                  pick_any,
    input  quad_idx_t                             pick_idx,
    input  logic [TILE_FRAGS-1:0]                 hold_cov,
    input  logic [TILE_FRAGS*ATTR_W-1:0]          hold_attr,
    input  logic [COORD_W-1:0]                    hold_x,
    input  logic [COORD_W-1:0]                    hold_y,
    input  logic [UNI_W-1:0]                      hold_uni,
    input  logic                                  hold_end,
    input  logic                                  out_free,
    output logic                                  take,
    output logic                                  release_tile,
    output logic                                  commit,
    output logic [CHUNK_QUADS*QUAD_FRAGS-1:0]     m_live,
    output logic [CHUNK_QUADS*QUAD_FRAGS*ATTR_W-1:0] m_attr,
    output logic [CHUNK_QUADS*(COORD_W+1)-1:0]    m_qx,
    output logic [CHUNK_QUADS*(COORD_W+1)-1:0]    m_qy,
    output logic [UNI_W-1:0]                      m_uni
);

    localparam int QC_W     = COORD_W + 1;
    localparam int QATTR_W  = QUAD_FRAGS * ATTR_W;
    localparam int FILL_W   = (CHUNK_QUADS > 1) ? $clog2(CHUNK_QUADS) : 1;

    logic [FILL_W-1:0]     fill;
    logic [UNI_W-1:0]      uni_r;
    logic                  last_slot;
    logic                  pend_flush;
    logic                  flush;
    logic [QUAD_FRAGS-1:0] new_live;
    logic [QATTR_W-1:0]    new_attr;
    logic [QC_W-1:0]       new_qx;
    logic [QC_W-1:0]       new_qy;

    // the selected quad's fields and its position derived from the tile corner
    assign new_live = hold_cov[pick_idx*QUAD_FRAGS +: QUAD_FRAGS];
    assign new_attr = hold_attr[pick_idx*QATTR_W +: QATTR_W];
    assign new_qx   = {hold_x, pick_idx[0]};
    assign new_qy   = {hold_y, pick_idx[QIDX_W-1]};

    // control: a quad that completes the chunk waits for a free output slot,
    // and so does the closing of a partial chunk at a triangle end
    always_comb begin
        last_slot    = (fill == FILL_W'(CHUNK_QUADS - 1));
        take         = hold_valid && pick_any && (!last_slot || out_free);
        pend_flush   = hold_valid && !pick_any && hold_end && (fill != '0);
        flush        = pend_flush && out_free;
        release_tile = hold_valid && !pick_any && (!pend_flush || out_free);
        commit       = (take && last_slot) || flush;
    end

    assign m_uni = (take && fill == '0) ? hold_uni : uni_r;

    // slot storage, one set of registers per quad slot
    for (genvar s = 0; s < CHUNK_QUADS; s++) begin : gen_slot
        logic                  slot_wr;
        logic [QUAD_FRAGS-1:0] live_q;
        logic [QATTR_W-1:0]    attr_q;
        logic [QC_W-1:0]       qx_q;
        logic [QC_W-1:0]       qy_q;

        assign slot_wr = take && (fill == FILL_W'(s));

        assign m_live[s*QUAD_FRAGS +: QUAD_FRAGS] = slot_wr ? new_live : live_q;
        assign m_attr[s*QATTR_W +: QATTR_W]       = slot_wr ? new_attr : attr_q;
        assign m_qx[s*QC_W +: QC_W]               = slot_wr ? new_qx   : qx_q;
        assign m_qy[s*QC_W +: QC_W]               = slot_wr ? new_qy   : qy_q;

        // write this slot when it is the fill point; clear liveness when the chunk leaves
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                live_q <= '0;
                attr_q <= '0;
                qx_q   <= '0;
                qy_q   <= '0;
            end else if (commit) begin
                live_q <= '0;
            end else if (slot_wr) begin
                live_q <= new_live;
                attr_q <= new_attr;
                qx_q   <= new_qx;
                qy_q   <= new_qy;
            end
        end
    end

    // fill pointer and the per-chunk uniform copy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill  <= '0;
            uni_r <= '0;
        end else begin
            if (commit) begin
                fill <= '0;
            end else if (take) begin
                fill <= fill + 1'b1;
            end
            if (take && fill == '0) begin
                uni_r <= hold_uni;
            end
        end
    end

endmodule

// File: rtl/fqp_out_reg.sv
// Single output register with a valid/ready handshake. Loads a closed chunk
// whenever out_free is high; out_free also covers the cycle in which the
// consumer drains the current chunk.
module fqp_out_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_data,
    input  logic         out_ready,
    output logic         out_valid,
    output logic [W-1:0] out_data,
    output logic         out_free
);

    assign out_free = !out_valid || out_ready;

    // hold the chunk until the consumer takes it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (load) begin
            out_valid <= 1'b1;
            out_data  <= load_data;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/fqp_chunk_packer.sv
// Top of the fragment quad chunk packer: takes one rasterized tile at a time,
// keeps its non-empty quads in ascending order, and emits fixed-size chunks
// with per-fragment, per-quad and per-chunk data. Assumes tile inputs are
// held while in_valid waits for in_ready.
module fqp_chunk_packer
    import fqp_pkg::*;
#(
    parameter int ATTR_W      = 8,
    parameter int COORD_W     = 8,
    parameter int UNI_W       = 16,
    parameter int CHUNK_QUADS = 4
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      in_valid,
    output logic                                      in_ready,
    input  logic [TILE_FRAGS-1:0]                     in_cov,
    input  logic [TILE_FRAGS*ATTR_W-1:0]              in_attr,
    input  logic [COORD_W-1:0]                        in_tile_x,
    input  logic [COORD_W-1:0]                        in_tile_y,
    input  logic [UNI_W-1:0]                          in_uniform,
    input  logic                                      in_tri_end,
    output logic                                      out_valid,
    input  logic                                      out_ready,
    output logic [CHUNK_QUADS*QUAD_FRAGS-1:0]         out_live,
    output logic [CHUNK_QUADS*QUAD_FRAGS*ATTR_W-1:0]  out_attr,
    output logic [CHUNK_QUADS*(COORD_W+1)-1:0]        out_quad_x,
    output logic [CHUNK_QUADS*(COORD_W+1)-1:0]        out_quad_y,
    output logic [UNI_W-1:0]                          out_uniform
);

    localparam int CF     = CHUNK_QUADS * QUAD_FRAGS;
    localparam int QC_W   = COORD_W + 1;
    localparam int BUS_W  = CF + CF * ATTR_W + 2 * CHUNK_QUADS * QC_W + UNI_W;

    logic                         hold_valid;
    logic [TILE_QUADS-1:0]        hold_rem;
    logic [TILE_FRAGS-1:0]        hold_cov;
    logic [TILE_FRAGS*ATTR_W-1:0] hold_attr;
    logic [COORD_W-1:0]           hold_x;
    logic [COORD_W-1:0]           hold_y;
    logic [UNI_W-1:0]             hold_uni;
    logic                         hold_end;
    logic                         pick_any;
    quad_idx_t                    pick_idx;
    logic                         take;
    logic                         release_tile;
    logic                         commit;
    logic                         out_free;
    logic [CF-1:0]                m_live;
    logic [CF*ATTR_W-1:0]         m_attr;
    logic [CHUNK_QUADS*QC_W-1:0]  m_qx;
    logic [CHUNK_QUADS*QC_W-1:0]  m_qy;
    logic [UNI_W-1:0]             m_uni;
    logic [BUS_W-1:0]             out_bus;

    fqp_tile_hold #(
        .ATTR_W (ATTR_W),
        .COORD_W(COORD_W),
        .UNI_W  (UNI_W)
    ) hold_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_ready    (in_ready),
        .in_cov      (in_cov),
        .in_attr     (in_attr),
        .in_tile_x   (in_tile_x),
        .in_tile_y   (in_tile_y),
        .in_uniform  (in_uniform),
        .in_tri_end  (in_tri_end),
        .take        (take),
        .take_idx    (pick_idx),
        .release_tile(release_tile),
        .hold_valid  (hold_valid),
        .hold_rem    (hold_rem),
        .hold_cov    (hold_cov),
        .hold_attr   (hold_attr),
        .hold_x      (hold_x),
        .hold_y      (hold_y),
        .hold_uni    (hold_uni),
        .hold_end    (hold_end)
    );

    fqp_quad_pick pick_i (
        .rem(hold_rem),
        .any(pick_any),
        .idx(pick_idx)
    );

    fqp_chunk_build #(
        .ATTR_W     (ATTR_W),
        .COORD_W    (COORD_W),
        .UNI_W      (UNI_W),
        .CHUNK_QUADS(CHUNK_QUADS)
    ) build_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .hold_valid  (hold_valid),
        .pick_any    (pick_any),
        .pick_idx    (pick_idx),
        .hold_cov    (hold_cov),
        .hold_attr   (hold_attr),
        .hold_x      (hold_x),
        .hold_y      (hold_y),
        .hold_uni    (hold_uni),
        .hold_end    (hold_end),
        .out_free    (out_free),
        .take        (take),
        .release_tile(release_tile),
        .commit      (commit),
        .m_live      (m_live),
        .m_attr      (m_attr),
        .m_qx        (m_qx),
        .m_qy        (m_qy),
        .m_uni       (m_uni)
    );

    fqp_out_reg #(
        .W(BUS_W)
    ) out_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (commit),
        .load_data({m_live, m_attr, m_qx, m_qy, m_uni}),
        .out_ready(out_ready),
        .out_valid(out_valid),
        .out_data (out_bus),
        .out_free (out_free)
    );

    assign {out_live, out_attr, out_quad_x, out_quad_y, out_uniform} = out_bus;

endmodule

// File: rtl/fqp_chunk_packer_chk.sv
// Property checker for the chunk packer, bound to every instance of the top.
// Sees only the top's ports.
module fqp_chunk_packer_chk
    import fqp_pkg::*;
#(
    parameter int ATTR_W      = 8,
    parameter int COORD_W     = 8,
    parameter int UNI_W       = 16,
    parameter int CHUNK_QUADS = 4
) (
    input logic                                     clk,
    input logic                                     rst_n,
    input logic                                     in_valid,
    input logic                                     in_ready,
    input logic                                     out_valid,
    input logic                                     out_ready,
    input logic [CHUNK_QUADS*QUAD_FRAGS-1:0]        out_live,
    input logic [CHUNK_QUADS*QUAD_FRAGS*ATTR_W-1:0] out_attr,
    input logic [CHUNK_QUADS*(COORD_W+1)-1:0]       out_quad_x,
    input logic [CHUNK_QUADS*(COORD_W+1)-1:0]       out_quad_y,
    input logic [UNI_W-1:0]                         out_uniform
);

    logic [CHUNK_QUADS-1:0] slot_used;
    logic                   was_rst = 1'b0;

    for (genvar s = 0; s < CHUNK_QUADS; s++) begin : gen_used
        assign slot_used[s] = |out_live[s*QUAD_FRAGS +: QUAD_FRAGS];
    end

    // remembers that the previous edge saw reset asserted
    always_ff @(posedge clk) begin
        was_rst <= !rst_n;
    end

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        was_rst |-> (!out_valid && in_ready));

    // R9
    no_empty_chunk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_live != '0));

    // R3
    packed_slots_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((slot_used & (slot_used + 1'b1)) == '0));

    // R10
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_live) && $stable(out_attr)
            && $stable(out_quad_x) && $stable(out_quad_y) && $stable(out_uniform)));

    // R11
    one_tile_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

endmodule

bind fqp_chunk_packer fqp_chunk_packer_chk #(
    .ATTR_W     (ATTR_W),
    .COORD_W    (COORD_W),
    .UNI_W      (UNI_W),
    .CHUNK_QUADS(CHUNK_QUADS)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_live   (out_live),
    .out_attr   (out_attr),
    .out_quad_x (out_quad_x),
    .out_quad_y (out_quad_y),
    .out_uniform(out_uniform)
);

// File: tb/fqp_chunk_packer_tb_top.sv
// Self-checking bench: a tile table walked twice (free-running and stalled
// consumer), then a directed reset case. Expected chunks come from a
// bench-side packing model of the requirements.
module fqp_chunk_packer_tb_top;
    import fqp_pkg::*;

    localparam int ATTR_W  = 8;
    localparam int COORD_W = 8;
    localparam int UNI_W   = 16;
    localparam int CQ      = 4;
    localparam int CF      = CQ * QUAD_FRAGS;
    localparam int QC_W    = COORD_W + 1;
    localparam int NT      = 13;
    localparam int MAXC    = 64;

    // {tri_end, coverage, chunks this tile is expected to close}
    localparam logic [18:0] TILES [NT] = '{
        {1'b0, 16'hFFFF, 2'd1},
        {1'b0, 16'h0F0F, 2'd0},
        {1'b1, 16'h8421, 2'd2},
        {1'b0, 16'h0000, 2'd0},
        {1'b1, 16'hF000, 2'd1},
        {1'b0, 16'h00F0, 2'd0},
        {1'b0, 16'h0F00, 2'd0},
        {1'b0, 16'h000F, 2'd0},
        {1'b1, 16'hFFF0, 2'd2},
        {1'b1, 16'h0000, 2'd0},
        {1'b0, 16'h1111, 2'd1},
        {1'b1, 16'h0000, 2'd0},
        {1'b1, 16'h6C3A, 2'd1}
    };

    logic                     clk = 1'b0;
    logic                     rst_n;
    logic                     in_valid;
    logic                     in_ready;
    logic [TILE_FRAGS-1:0]    in_cov;
    logic [TILE_FRAGS*ATTR_W-1:0] in_attr;
    logic [COORD_W-1:0]       in_tile_x;
    logic [COORD_W-1:0]       in_tile_y;
    logic [UNI_W-1:0]         in_uniform;
    logic                     in_tri_end;
    logic                     out_valid;
    logic                     out_ready;
    logic [CF-1:0]            out_live;
    logic [CF*ATTR_W-1:0]     out_attr;
    logic [CQ*QC_W-1:0]       out_quad_x;
    logic [CQ*QC_W-1:0]       out_quad_y;
    logic [UNI_W-1:0]         out_uniform;

    always #5 clk = ~clk;

    fqp_chunk_packer #(
        .ATTR_W(ATTR_W), .COORD_W(COORD_W), .UNI_W(UNI_W), .CHUNK_QUADS(CQ)
    ) dut_i (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_cov(in_cov), .in_attr(in_attr),
        .in_tile_x(in_tile_x), .in_tile_y(in_tile_y), .in_uniform(in_uniform),
        .in_tri_end(in_tri_end),
        .out_valid(out_valid), .out_ready(out_ready), .out_live(out_live),
        .out_attr(out_attr), .out_quad_x(out_quad_x), .out_quad_y(out_quad_y),
        .out_uniform(out_uniform)
    );

    int n_chk = 0;
    int n_fail = 0;
    int rcv = 0;
    int wr = 0;
    int rd = 0;
    int cyc = 0;
    bit stall_mode = 1'b0;

    logic [CF-1:0]        e_live [MAXC];
    logic [CF*ATTR_W-1:0] e_attr [MAXC];
    logic [CQ*QC_W-1:0]   e_qx   [MAXC];
    logic [CQ*QC_W-1:0]   e_qy   [MAXC];
    logic [UNI_W-1:0]     e_uni  [MAXC];
    logic [CQ-1:0]        e_used [MAXC];

    logic [CF-1:0]        m_live = '0;
    logic [CF*ATTR_W-1:0] m_attr = '0;
    logic [CQ*QC_W-1:0]   m_qx = '0;
    logic [CQ*QC_W-1:0]   m_qy = '0;
    logic [UNI_W-1:0]     m_uni = '0;
    logic [CQ-1:0]        m_used = '0;
    int                   m_fill = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [ATTR_W-1:0] attr_of(input int tag, input int f);
        return ATTR_W'(tag * 16 + f * 5 + 1);
    endfunction

    task automatic model_push();
        e_live[wr] = m_live;
        e_attr[wr] = m_attr;
        e_qx[wr]   = m_qx;
        e_qy[wr]   = m_qy;
        e_uni[wr]  = m_uni;
        e_used[wr] = m_used;
        wr++;
        m_live = '0;
        m_used = '0;
        m_fill = 0;
    endtask

    task automatic model_reset();
        m_live = '0;
        m_used = '0;
        m_fill = 0;
    endtask

    // packing model written from R2..R8
    task automatic model_tile(input logic [15:0] cov, input bit te, input int tag,
                              input logic [7:0] tx, input logic [7:0] ty,
                              input logic [15:0] uni);
        for (int q = 0; q < 4; q++) begin
            logic [3:0] nib;
            nib = cov[q*4 +: 4];
            if (nib != 4'h0) begin
                m_live[m_fill*4 +: 4] = nib;
                for (int f = 0; f < 4; f++) begin
                    m_attr[(m_fill*4+f)*ATTR_W +: ATTR_W] = attr_of(tag, q*4+f);
                end
                m_qx[m_fill*QC_W +: QC_W] = {tx, 1'(q & 1)};
                m_qy[m_fill*QC_W +: QC_W] = {ty, 1'(q >> 1)};
                m_used[m_fill] = 1'b1;
                m_uni = uni;
                m_fill++;
                if (m_fill == CQ) model_push();
            end
        end
        if (te && m_fill != 0) model_push();
    endtask

    task automatic send_tile(input logic [15:0] cov, input bit te, input int tag,
                             input logic [15:0] uni);
        logic [7:0] tx;
        logic [7:0] ty;
        tx = 8'(tag * 3 + 5);
        ty = 8'(200 - tag);
        model_tile(cov, te, tag, tx, ty, uni);
        @(posedge clk);
        #1;
        in_valid   = 1'b1;
        in_cov     = cov;
        in_tile_x  = tx;
        in_tile_y  = ty;
        in_uniform = uni;
        in_tri_end = te;
        for (int f = 0; f < 16; f++) in_attr[f*ATTR_W +: ATTR_W] = attr_of(tag, f);
        do @(negedge clk); while (!in_ready);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        @(negedge clk);
        // R11: tile is still held right after acceptance
        check(!in_ready, "R11", "in_ready after accept", 128'(in_ready), 128'(0));
    endtask

    task automatic wait_count(input int target);
        for (int k = 0; k < 60 && rcv < target; k++) @(negedge clk);
        repeat (8) @(negedge clk);
        // R7 R8 R9: exactly the expected number of chunks closed so far
        check(rcv == target, "R7 R8 R9", "chunk count", 128'(rcv), 128'(target));
    endtask

    // consumer ready pattern
    initial begin
        out_ready = 1'b1;
        forever begin
            @(posedge clk);
            #1;
            cyc++;
            out_ready = !stall_mode || (cyc % 4 == 0) || (cyc % 4 == 3);
        end
    end

    // output monitor against the expected chunk list
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            if (rd >= wr) begin
                check(1'b0, "R9", "unexpected chunk", 128'(out_live), 128'(0));
            end else begin
                logic [CF*ATTR_W-1:0] amask;
                logic [CQ*QC_W-1:0]   pmask;
                amask = '0;
                pmask = '0;
                for (int s = 0; s < CQ; s++) begin
                    if (e_used[rd][s]) begin
                        amask[s*QUAD_FRAGS*ATTR_W +: QUAD_FRAGS*ATTR_W] = '1;
                        pmask[s*QC_W +: QC_W] = '1;
                    end
                end
                check(out_live == e_live[rd], "R2 R3 R5 R8", "liveness",
                      128'(out_live), 128'(e_live[rd]));
                check(((out_attr ^ e_attr[rd]) & amask) == '0, "R2 R5", "attributes",
                      out_attr & amask, e_attr[rd] & amask);
                check(((out_quad_x ^ e_qx[rd]) & pmask) == '0 &&
                      ((out_quad_y ^ e_qy[rd]) & pmask) == '0, "R4", "quad positions",
                      128'({out_quad_x & pmask, out_quad_y & pmask}),
                      128'({e_qx[rd] & pmask, e_qy[rd] & pmask}));
                check(out_uniform == e_uni[rd], "R6", "uniform",
                      128'(out_uniform), 128'(e_uni[rd]));
                rd++;
            end
            rcv++;
        end
    end

    // R10: a stalled chunk must stay put
    logic                 stall_seen = 1'b0;
    logic [CF-1:0]        sv_live;
    logic [CF*ATTR_W-1:0] sv_attr;
    logic [CQ*QC_W-1:0]   sv_qx;
    logic [UNI_W-1:0]     sv_uni;
    always @(negedge clk) begin
        if (rst_n && stall_seen) begin
            check(out_valid && out_live == sv_live && out_attr == sv_attr &&
                  out_quad_x == sv_qx && out_uniform == sv_uni, "R10", "held chunk",
                  128'({out_valid, out_live}), 128'({1'b1, sv_live}));
        end
        stall_seen = rst_n && out_valid && !out_ready;
        sv_live = out_live;
        sv_attr = out_attr;
        sv_qx   = out_quad_x;
        sv_uni  = out_uniform;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int cum;
        int tri_no;
        cum = 0;
        tri_no = 0;
        rst_n = 1'b0;
        in_valid = 1'b0;
        in_cov = '0;
        in_attr = '0;
        in_tile_x = '0;
        in_tile_y = '0;
        in_uniform = '0;
        in_tri_end = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle after reset
        check(!out_valid && in_ready, "R1", "state after reset",
              128'({out_valid, in_ready}), 128'({1'b0, 1'b1}));

        for (int pass = 0; pass < 2; pass++) begin
            stall_mode = (pass == 1);
            for (int i = 0; i < NT; i++) begin
                logic [18:0] ent;
                ent = TILES[i];
                cum += int'(ent[1:0]);
                send_tile(ent[17:2], ent[18], pass * 20 + i, 16'(16'hA000 + tri_no));
                if (ent[18]) tri_no++;
                wait_count(cum);
            end
        end

        // R1: reset drops a partly filled chunk
        stall_mode = 1'b0;
        send_tile(16'h00FF, 1'b0, 90, 16'h5A5A);
        wait_count(cum);
        @(posedge clk);
        #1;
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        rst_n = 1'b1;
        model_reset();
        @(negedge clk);
        check(!out_valid && in_ready, "R1", "state after mid-run reset",
              128'({out_valid, in_ready}), 128'({1'b0, 1'b1}));
        send_tile(16'h0F00, 1'b1, 91, 16'hC3C3);
        cum += 1;
        wait_count(cum);

        check(rd == wr, "R10", "all chunks delivered", 128'(rd), 128'(wr));
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule